// File: doc/BRIEF.md
# Time Slot Interchange Core

This block moves byte-wide time slots between serial TDM streams that share one 8 kHz frame. The bit-level serialisers sit outside the block. Every clock cycle is one channel time slot. In that cycle the block takes one byte from each input stream and presents one byte, with a drive enable, for each output stream. A channel counter marks the slot position. The counter restarts on a frame pulse or when it reaches the parameterised channel count.

Incoming bytes are stored in a data memory of three frame banks, selected by frame number modulo three. A connection memory holds one entry for each output stream and channel. The entry says where that output slot gets its byte. It can take a chosen input stream and channel from data memory, using either minimum-latency timing or frame-integrity timing. It can instead send a fixed byte supplied by the host. The entry also carries a drive enable for the slot and a loopback flag. A simple host RAM port writes and reads the connection memory, reads the data memory, and sets a standby bit. The global drive input and the standby bit act as a master enable over all slot enables.

Top module: `tsi_core`

## Requirements
- R1: While reset is held and right after it, every `txEn` bit is 0, the standby bit reads back 0, the first slot after reset is channel 0 of frame 0, and connection memory holds 0 (every slot tri-stated).
- R2: The channel counter advances by one per cycle and wraps after `NUM_CHANNELS-1`. A `framePulse` sampled high makes the next cycle channel 0 of a new frame, even in the middle of a frame.
- R3: A connection word is laid out as follows. Bit 15 is loopback. Bit 14 selects constant delay (1) or variable delay (0). Bit 13 selects processor channel. Bit 12 is the slot enable. Bits 11:7 give the source stream. Bits 6:0 give the source channel. A host read of a connection entry returns the word last written there.
- R4: When bit 13 is set, bits 7:0 of the word go out on that slot in every frame, until the host rewrites the entry.
- R5: In variable mode, output channel m takes source channel n from the current frame when m > n+2. Otherwise it takes it from the previous frame.
- R6: In constant mode, a byte stored during frame k goes out during frame k+2, whatever the channel numbers.
- R7: `txEn[s]` is 0 whenever the slot enable bit is 0. When the slot enable bit is 1, `txEn[s]` is 1 if `driveAll` or the standby bit is 1, and 0 only when both are 0.
- R8: Several output slots can name the same source byte, and each of them carries that byte.
- R9: When bit 15 of the entry for output stream s, channel m is set, data memory for input stream s, channel m stores the byte that slot sends, in place of `rxData`.
- R10: A host write to a connection entry takes effect from the next cycle in which that slot is output.
- R11: The host address is {region[1:0], stream[4:0], channel[6:0]}. Region 2'b10 gives read and write access to connection memory. Region 2'b11 reads the data memory byte of the most recently completed frame. Region 2'b01 is the control word, where bit 0 is the standby bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, one channel per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| framePulse | input | 1 | Frame start; the next cycle is channel 0 |
| driveAll | input | 1 | Global output drive enable |
| rxData | input | NUM_STREAMS*8 | Input byte per stream, stream s at [8s+7:8s] |
| txData | output | NUM_STREAMS*8 | Output byte per stream for the current slot |
| txEn | output | NUM_STREAMS | Drive enable per output stream for the current slot |
| hostAddr | input | 14 | Host address {region, stream, channel} |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, combinational from hostAddr |

## Verification
A wrong bank index shows up as output bytes that belong to the wrong frame. The effect appears in the first frame in which a variable-mode or constant-mode slot is read, and in the same cycle as that slot. A channel counter that drifts after an early frame pulse puts every following slot in the wrong position, so a host-supplied byte is missing from the channel it was programmed for in the very next cycle. An error in the enable logic appears as a wrong `txEn` in the same cycle as the `driveAll` change or the standby write that exposes it.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int NUM_BANKS = 3;

  // Host address regions (upper two address bits)
  localparam logic [1:0] REG_CTRL = 2'b01;
  localparam logic [1:0] REG_CONN = 2'b10;
  localparam logic [1:0] REG_DATA = 2'b11;

  typedef struct packed {
    logic       loopBack;
    logic       constDelay;
    logic       procChan;
    logic       slotEnable;
    logic [4:0] srcStream;
    logic [6:0] srcChan;
  } connWord_t;

  typedef struct packed {
    logic [6:0] chan;
    logic [1:0] wrBank;
    logic [1:0] prevBank;
    logic [1:0] oldBank;
    logic       connWr;
    logic       ctrlWr;
  } slotStrobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int NUM_CHANNELS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        framePulse,
  input  logic        hostWr,
  input  logic [1:0]  hostRegion,
  output slotStrobe_t strobe
);
  localparam logic [6:0] LAST_CHAN = 7'(NUM_CHANNELS - 1);
  localparam logic [1:0] TOP_BANK  = 2'(NUM_BANKS - 1);

  logic [6:0] chanQ;
  logic [1:0] bankQ;
  logic       frameStart;

  assign frameStart = framePulse || (chanQ == LAST_CHAN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ <= '0;
      bankQ <= '0;
    end else if (frameStart) begin
      chanQ <= '0;
      bankQ <= (bankQ == TOP_BANK) ? 2'd0 : bankQ + 2'd1;
    end else begin
      chanQ <= chanQ + 7'd1;
    end
  end

  always_comb begin
    strobe.chan     = chanQ;
    strobe.wrBank   = bankQ;
    strobe.prevBank = (bankQ == 2'd0) ? TOP_BANK : bankQ - 2'd1;
    strobe.oldBank  = (bankQ == TOP_BANK) ? 2'd0 : bankQ + 2'd1;
    strobe.connWr   = hostWr && (hostRegion == REG_CONN);
    strobe.ctrlWr   = hostWr && (hostRegion == REG_CTRL);
  end

  // R2
  chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanQ <= LAST_CHAN);
  // R2
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> (chanQ == 7'd0));
  // R6
  bank_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (bankQ != $past(bankQ)));
  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(bankQ));
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS  = 4,
  parameter int NUM_CHANNELS = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  slotStrobe_t              strobe,
  input  logic                     driveAll,
  input  logic [NUM_STREAMS*8-1:0] rxData,
  output logic [NUM_STREAMS*8-1:0] txData,
  output logic [NUM_STREAMS-1:0]   txEn,
  input  logic [13:0]              hostAddr,
  input  logic [15:0]              hostWdata,
  output logic [15:0]              hostRdata
);
  connWord_t  connMem [NUM_STREAMS][NUM_CHANNELS];
  logic [7:0] dataMem [NUM_BANKS][NUM_STREAMS][NUM_CHANNELS];
  logic       standbyQ;

  logic [4:0] hostStream;
  logic [6:0] hostChan;
  assign hostStream = hostAddr[11:7];
  assign hostChan   = hostAddr[6:0];

  // Per output stream slot selection
  for (genvar o = 0; o < NUM_STREAMS; o++) begin : g_out
    connWord_t  word;
    logic       sameFrame;
    logic [1:0] rdBank;
    assign word      = connMem[o][strobe.chan];
    assign sameFrame = {1'b0, strobe.chan} > ({1'b0, word.srcChan} + 8'd2);
    assign rdBank    = word.constDelay ? strobe.oldBank
                     : (sameFrame ? strobe.wrBank : strobe.prevBank);
    assign txData[o*8 +: 8] = word.procChan ? word[7:0]
                            : dataMem[rdBank][word.srcStream][word.srcChan];
    assign txEn[o] = word.slotEnable && (driveAll || standbyQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      standbyQ <= 1'b0;
      for (int s = 0; s < NUM_STREAMS; s++)
        for (int ch = 0; ch < NUM_CHANNELS; ch++) begin
          connMem[s][ch] <= '0;
          for (int b = 0; b < NUM_BANKS; b++) dataMem[b][s][ch] <= '0;
        end
    end else begin
      if (strobe.ctrlWr) standbyQ <= hostWdata[0];
      if (strobe.connWr) connMem[hostStream][hostChan] <= connWord_t'(hostWdata);
      for (int s = 0; s < NUM_STREAMS; s++)
        dataMem[strobe.wrBank][s][strobe.chan] <=
          connMem[s][strobe.chan].loopBack ? txData[s*8 +: 8] : rxData[s*8 +: 8];
    end
  end

  always_comb begin
    case (hostAddr[13:12])
      REG_CONN: hostRdata = 16'(connMem[hostStream][hostChan]);
      REG_DATA: hostRdata = {8'd0, dataMem[strobe.prevBank][hostStream][hostChan]};
      REG_CTRL: hostRdata = {15'd0, standbyQ};
      default:  hostRdata = '0;
    endcase
  end

  // R7
  idle_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!driveAll && !standbyQ) |-> (txEn == '0));
endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
#(
  parameter int NUM_STREAMS  = 4,
  parameter int NUM_CHANNELS = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     framePulse,
  input  logic                     driveAll,
  input  logic [NUM_STREAMS*8-1:0] rxData,
  output logic [NUM_STREAMS*8-1:0] txData,
  output logic [NUM_STREAMS-1:0]   txEn,
  input  logic [13:0]              hostAddr,
  input  logic                     hostWr,
  input  logic [15:0]              hostWdata,
  output logic [15:0]              hostRdata
);
  slotStrobe_t strobe;

  tsi_ctrl #(.NUM_CHANNELS(NUM_CHANNELS)) u_ctrl (
    .clk(clk), .rstN(rstN), .framePulse(framePulse),
    .hostWr(hostWr), .hostRegion(hostAddr[13:12]), .strobe(strobe)
  );

  tsi_datapath #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .driveAll(driveAll),
    .rxData(rxData), .txData(txData), .txEn(txEn),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );
endmodule

// File: tb/tsi_core_test.sv
module tsi_core_test;
  localparam int NS = 4;
  localparam int NC = 32;
  localparam logic [13:0] CTRL_ADDR = 14'h1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rstN, framePulse, driveAll, hostWr;
  logic [NS*8-1:0] rxData, txData;
  logic [NS-1:0]  txEn;
  logic [13:0]    hostAddr;
  logic [15:0]    hostWdata, hostRdata;

  tsi_core #(.NUM_STREAMS(NS), .NUM_CHANNELS(NC)) uut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .driveAll(driveAll),
    .rxData(rxData), .txData(txData), .txEn(txEn), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  int  f = 0, c = 0, checks = 0, fails = 0;
  bit  checkOn = 0;

  // {output stream, output channel, connection word}
  localparam logic [31:0] VEC [10] = '{
    {8'd0, 8'd10, 16'h1083},  // var s1 n3, same frame
    {8'd0, 8'd4,  16'h1102},  // var s2 n2, previous frame
    {8'd1, 8'd0,  16'h519F},  // const s3 n31
    {8'd1, 8'd31, 16'h5000},  // const s0 n0
    {8'd2, 8'd7,  16'h305A},  // processor byte 5A
    {8'd3, 8'd10, 16'h1083},  // multicast of s1 n3
    {8'd3, 8'd3,  16'h1003},  // var s0 n3, previous frame
    {8'd2, 8'd9,  16'h0000},  // slot disabled
    {8'd1, 8'd5,  16'hB0A5},  // loopback processor byte A5
    {8'd2, 8'd20, 16'h1085}   // var s1 n5, fed by loopback
  };

  function automatic logic [7:0] pat(int fr, int s, int ch);
    if (fr < 0) return 8'd0;
    return 8'(fr * 71 + s * 53 + ch * 7 + 3);
  endfunction

  function automatic logic [13:0] connAddr(int s, int ch);
    return {2'b10, 5'(s), 7'(ch)};
  endfunction

  function automatic logic [13:0] dataAddr(int s, int ch);
    return {2'b11, 5'(s), 7'(ch)};
  endfunction

  function automatic logic [7:0] expByte(logic [15:0] w, int m, int fr);
    int s, n;
    s = int'(w[11:7]);
    n = int'(w[6:0]);
    if (w[13]) return w[7:0];
    if (s == 1 && n == 5) return 8'hA5;
    if (w[14]) return pat(fr - 2, s, n);
    if (m > n + 2) return pat(fr, s, n);
    return pat(fr - 1, s, n);
  endfunction

  function automatic string tagOf(int idx, logic [15:0] w);
    if (idx == 5) return "R8";
    if (w[15] || (w[11:7] == 5'd1 && w[6:0] == 7'd5)) return "R9";
    if (!w[12]) return "R7";
    if (w[13]) return "R4";
    if (w[14]) return "R6";
    return "R5";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s frame=%0d chan=%0d actual=%0h expected=%0h", tag, f, c, act, expv);
    end
  endtask

  task automatic drive(bit pulse);
    for (int s = 0; s < NS; s++) rxData[s*8 +: 8] = pat(f, s, c);
    framePulse = pulse || (c == NC - 1);
    #1;
    if (checkOn)
      for (int i = 0; i < 10; i++) begin
        int o, m;
        o = int'(VEC[i][31:24]);
        m = int'(VEC[i][23:16]);
        if (m == c) begin
          check(tagOf(i, VEC[i][15:0]), 16'(txEn[o]), 16'(VEC[i][12]));
          if (VEC[i][12])
            check(tagOf(i, VEC[i][15:0]), 16'(txData[o*8 +: 8]),
                  16'(expByte(VEC[i][15:0], m, f)));
        end
      end
  endtask

  task automatic tick();
    @(negedge clk);
    if (framePulse) begin c = 0; f++; end
    else c++;
  endtask

  task automatic hostWrite(logic [13:0] a, logic [15:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    drive(0);
    tick();
    hostWr = 1'b0;
  endtask

  task automatic runTo(int fr, int ch);
    while (!(f == fr && c == ch)) begin drive(0); tick(); end
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; framePulse = 1'b0; driveAll = 1'b0; hostWr = 1'b0;
    hostWdata = '0; rxData = '0; hostAddr = CTRL_ADDR;
    repeat (3) @(negedge clk);
    #1;
    check("R1 txEn in reset", 16'(txEn), 16'd0);
    check("R1 standby in reset", hostRdata, 16'd0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 txEn after reset", 16'(txEn), 16'd0);
    f = 0; c = 0;

    // Program standby and the connection table
    hostWrite(CTRL_ADDR, 16'd1);
    for (int i = 0; i < 10; i++)
      hostWrite(connAddr(int'(VEC[i][31:24]), int'(VEC[i][23:16])), VEC[i][15:0]);

    runTo(4, 0);
    checkOn = 1;
    while (f < 6) begin
      if (c == 12) begin
        int fr;
        fr = f;
        hostAddr = dataAddr(2, 7);
        drive(0);
        check("R11 data read previous frame", hostRdata, 16'(pat(fr - 1, 2, 7)));
        tick();
      end else if (c == 13) begin
        hostAddr = dataAddr(1, 5);
        drive(0);
        check("R9 looped byte stored", hostRdata, 16'h00A5);
        tick();
      end else begin
        drive(0); tick();
      end
    end
    checkOn = 0;

    // Master enable priority
    hostWrite(CTRL_ADDR, 16'd0);
    runTo(6, 10);
    drive(0);
    check("R7 both masters off", 16'(txEn), 16'd0);
    tick();
    driveAll = 1'b1;
    runTo(7, 9);
    drive(0);
    check("R7 slot enable 0 wins", 16'(txEn[2]), 16'd0);
    tick();
    drive(0);
    check("R7 drive pin enables", 16'(txEn[0]), 16'd1);
    check("R5 same frame source", 16'(txData[7:0]), 16'(pat(7, 1, 3)));
    tick();

    // Host write effective from next slot, readback layout
    runTo(7, 14);
    hostWrite(connAddr(0, 15), 16'h3033);
    hostAddr = connAddr(0, 15);
    drive(0);
    check("R10 new byte next slot", 16'(txData[7:0]), 16'h0033);
    check("R10 new enable next slot", 16'(txEn[0]), 16'd1);
    check("R3 connection readback", hostRdata, 16'h3033);
    tick();

    // Early frame pulse
    runTo(7, 20);
    hostWrite(connAddr(0, 0), 16'h3077);
    runTo(7, 25);
    drive(1);
    tick();
    drive(0);
    check("R2 early pulse gives channel 0", 16'(txData[7:0]), 16'h0077);
    check("R2 early pulse slot enable", 16'(txEn[0]), 16'd1);
    tick();
    runTo(8, 10);
    drive(0);
    check("R2 realigned frame data", 16'(txData[7:0]), 16'(pat(8, 1, 3)));
    tick();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule